// File: doc/BRIEF.md
# Single-Precision Floating-Point Instruction Decoder

This block is a purely combinational decoder for the 32-bit single-precision floating-point instructions of a RISC-V style core. It looks at one 32-bit instruction word and reports which operation the word asks for. It also reports the four register index fields and the sign-extended memory offset. Two flags tell the issue logic whether the first source and the destination belong to the integer register file or the floating-point register file. The second and third sources are always floating-point registers.

The decoder covers the following operations:
- memory load and store;
- the four fused multiply-add forms;
- add, subtract, multiply, divide and square root;
- the three sign-injection variants and minimum;
- the three compares and classify;
- the raw bit moves between register files;
- the conversions between float and 32-bit or 64-bit integers, in both directions.

Any word outside this map raises `illegal_o` and forces the operation code to the no-op value. A parameter `INT_XLEN` (32 or 64) sets the integer width. With 32, the 64-bit integer conversions are treated as illegal. Execution of the operations is not part of this block.

Top module: `fp_insn_decoder`

## Requirements
- R1: `op_o` uses this numbering: 0 no-op, 1 load, 2 store, 3 multiply-add, 4 multiply-subtract, 5 negated multiply-add, 6 negated multiply-subtract, 7 add, 8 sub, 9 mul, 10 div, 11 square root, 12 sign copy, 13 sign negate, 14 sign xor, 15 min, 16 equal, 17 less-than, 18 less-or-equal, 19/20/21/22 float to signed32/unsigned32/signed64/unsigned64, 23/24/25/26 signed32/unsigned32/signed64/unsigned64 to float, 27 move float bits to integer, 28 classify, 29 move integer bits to float.
- R2: Opcode bits[6:0]=0000111 with bits[14:12]=010 decodes as load. The immediate is bits[31:20] sign-extended to 32 bits, `rs1_int_o`=1 and `rd_int_o`=0.
- R3: Opcode 0100111 with bits[14:12]=010 decodes as store. The immediate is {bits[31:25], bits[11:7]} sign-extended to 32 bits, `rs1_int_o`=1 and `rd_int_o`=0.
- R4: Opcodes 1000011, 1000111, 1001111 and 1001011 decode as multiply-add, multiply-subtract, negated multiply-add and negated multiply-subtract. `rs3_o` is bits[31:27]. Bits[26:25] must be 00, and any other value is illegal.
- R5: Opcode 1010011 with bits[31:25] equal to 0000000, 0000100, 0001000 or 0001100 decodes as add, sub, mul or div, for any bits[14:12] (the rounding mode). Bits[31:25]=0101100 decodes as square root only when bits[24:20]=0.
- R6: Bits[31:25]=0010000 with bits[14:12]=000, 001 or 010 decodes as sign copy, sign negate or sign xor. Any other bits[14:12] value is illegal.
- R7: Bits[31:25]=0010100 decodes as min only when bits[14:12]=000.
- R8: Bits[31:25]=1010000 with bits[14:12]=010, 001 or 000 decodes as equal, less-than or less-or-equal, with `rd_int_o`=1. Any other bits[14:12] value is illegal.
- R9: Bits[31:25]=1100000 (float to integer, `rd_int_o`=1) and 1101000 (integer to float, `rs1_int_o`=1) choose the integer type from bits[24:20]: 0 signed32, 1 unsigned32, 2 signed64, 3 unsigned64. A value of 4 or more is illegal.
- R10: The 64-bit conversion types (bits[24:20]=2 or 3) are legal only when `INT_XLEN`=64. Otherwise they are illegal.
- R11: Bits[31:25]=1110000 with bits[24:20]=0 decodes as the bit move to integer (bits[14:12]=000) or as classify (001), both with `rd_int_o`=1. Bits[31:25]=1111000 with bits[14:12]=000 and bits[24:20]=0 decodes as the bit move to float, with `rs1_int_o`=1.
- R12: Any word not matched by R2 to R11 drives `illegal_o`=1, `op_o`=0, both file flags 0 and the immediate 0.
- R13: `rd_o`, `rs1_o` and `rs2_o` always show bits[11:7], [19:15] and [24:20]. The immediate is 0 for every operation other than load and store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word |
| op_o | output | 5 | Operation code, numbered as in R1 |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| rs3_o | output | 5 | Third source index for the fused forms |
| imm_o | output | 32 | Sign-extended load/store offset |
| rs1_int_o | output | 1 | First source is in the integer file |
| rd_int_o | output | 1 | Destination is in the integer file |
| illegal_o | output | 1 | Word is not a supported instruction |

## Verification
The memory forms are tried with negative, most-negative and most-positive offsets. This shows that the load and store immediates come from different bit fields and are sign-extended correctly. Each arithmetic, sign-injection, compare and move form is applied once with a legal sub-field and once with a neighbouring illegal value of funct3, rs2 or the format bits. This separates a check on the whole field from a check on only some of its bits. The conversions are run on two instances, one built for 32-bit integers and one for 64-bit integers, so that the 64-bit types are shown to depend on the parameter.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;

  localparam int INSN_W = 32;
  localparam int REG_W  = 5;
  localparam int OP_W   = 5;

  // major opcodes
  localparam logic [6:0] OPC_FLOAD  = 7'b0000111;
  localparam logic [6:0] OPC_FSTORE = 7'b0100111;
  localparam logic [6:0] OPC_FMA    = 7'b1000011;
  localparam logic [6:0] OPC_FMS    = 7'b1000111;
  localparam logic [6:0] OPC_FNMS   = 7'b1001011;
  localparam logic [6:0] OPC_FNMA   = 7'b1001111;
  localparam logic [6:0] OPC_FPU    = 7'b1010011;

  // upper function field values under OPC_FPU
  localparam logic [6:0] F7_ADD  = 7'b0000000;
  localparam logic [6:0] F7_SUB  = 7'b0000100;
  localparam logic [6:0] F7_MUL  = 7'b0001000;
  localparam logic [6:0] F7_DIV  = 7'b0001100;
  localparam logic [6:0] F7_SQRT = 7'b0101100;
  localparam logic [6:0] F7_SGN  = 7'b0010000;
  localparam logic [6:0] F7_MIN  = 7'b0010100;
  localparam logic [6:0] F7_CMP  = 7'b1010000;
  localparam logic [6:0] F7_F2I  = 7'b1100000;
  localparam logic [6:0] F7_I2F  = 7'b1101000;
  localparam logic [6:0] F7_MVX  = 7'b1110000;
  localparam logic [6:0] F7_MVF  = 7'b1111000;

  localparam logic [2:0] MEM_WIDTH_WORD = 3'b010;

  typedef enum logic [OP_W-1:0] {
    OP_NOP        = 5'd0,
    OP_FLOAD      = 5'd1,
    OP_FSTORE     = 5'd2,
    OP_FMA        = 5'd3,
    OP_FMS        = 5'd4,
    OP_FNMA       = 5'd5,
    OP_FNMS       = 5'd6,
    OP_FADD       = 5'd7,
    OP_FSUB       = 5'd8,
    OP_FMUL       = 5'd9,
    OP_FDIV       = 5'd10,
    OP_FROOT      = 5'd11,
    OP_SIGN_COPY  = 5'd12,
    OP_SIGN_NEG   = 5'd13,
    OP_SIGN_XOR   = 5'd14,
    OP_FMIN       = 5'd15,
    OP_CMP_EQ     = 5'd16,
    OP_CMP_LT     = 5'd17,
    OP_CMP_LE     = 5'd18,
    OP_F2I_S32    = 5'd19,
    OP_F2I_U32    = 5'd20,
    OP_F2I_S64    = 5'd21,
    OP_F2I_U64    = 5'd22,
    OP_I2F_S32    = 5'd23,
    OP_I2F_U32    = 5'd24,
    OP_I2F_S64    = 5'd25,
    OP_I2F_U64    = 5'd26,
    OP_BITS_F2I   = 5'd27,
    OP_CLASSIFY   = 5'd28,
    OP_BITS_I2F   = 5'd29
  } fp_op_e;

  typedef enum logic [1:0] {
    IMM_NONE  = 2'd0,
    IMM_LOAD  = 2'd1,
    IMM_STORE = 2'd2
  } imm_kind_e;

endpackage

// File: rtl/fpdec_fields.sv
module fpdec_fields
  import fpdec_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [INSN_W-1:0] insn_i,
  output logic [6:0]        opcode_o,
  output logic [2:0]        funct3_o,
  output logic [6:0]        funct7_o,
  output logic [REG_W-1:0]  rd_o,
  output logic [REG_W-1:0]  rs1_o,
  output logic [REG_W-1:0]  rs2_o,
  output logic [REG_W-1:0]  rs3_o,
  output logic [IMM_W-1:0]  imm_ld_o,
  output logic [IMM_W-1:0]  imm_st_o
);
  localparam int OFS_W = 12;
  localparam int EXT_W = IMM_W - OFS_W;

  logic [OFS_W-1:0] ofs_ld;
  logic [OFS_W-1:0] ofs_st;

  always_comb begin
    opcode_o = insn_i[6:0];
    rd_o     = insn_i[11:7];
    funct3_o = insn_i[14:12];
    rs1_o    = insn_i[19:15];
    rs2_o    = insn_i[24:20];
    funct7_o = insn_i[31:25];
    rs3_o    = insn_i[31:27];
    ofs_ld   = insn_i[31:20];
    ofs_st   = {insn_i[31:25], insn_i[11:7]};
    imm_ld_o = {{EXT_W{ofs_ld[OFS_W-1]}}, ofs_ld};
    imm_st_o = {{EXT_W{ofs_st[OFS_W-1]}}, ofs_st};
  end

endmodule

// File: rtl/fpdec_opmap.sv
module fpdec_opmap
  import fpdec_pkg::*;
#(
  parameter int INT_XLEN = 32
) (
  input  logic [6:0]       opcode_i,
  input  logic [2:0]       funct3_i,
  input  logic [6:0]       funct7_i,
  input  logic [REG_W-1:0] rs2_i,
  output fp_op_e           op_o,
  output imm_kind_e        imm_kind_o,
  output logic             rs1_int_o,
  output logic             rd_int_o,
  output logic             illegal_o
);
  localparam bit WIDE_OK = (INT_XLEN >= 64);

  logic       rs2_zero;
  logic       conv_ok;
  logic [1:0] conv_sel;

  always_comb begin
    rs2_zero = (rs2_i == '0);
    conv_sel = rs2_i[1:0];
    conv_ok  = (rs2_i[REG_W-1:2] == '0) && (!conv_sel[1] || WIDE_OK);
  end

  always_comb begin
    op_o       = OP_NOP;
    imm_kind_o = IMM_NONE;
    rs1_int_o  = 1'b0;
    rd_int_o   = 1'b0;
    unique case (opcode_i)
      OPC_FLOAD: if (funct3_i == MEM_WIDTH_WORD) begin
        op_o = OP_FLOAD; imm_kind_o = IMM_LOAD; rs1_int_o = 1'b1;
      end
      OPC_FSTORE: if (funct3_i == MEM_WIDTH_WORD) begin
        op_o = OP_FSTORE; imm_kind_o = IMM_STORE; rs1_int_o = 1'b1;
      end
      OPC_FMA:  if (funct7_i[1:0] == 2'b00) op_o = OP_FMA;
      OPC_FMS:  if (funct7_i[1:0] == 2'b00) op_o = OP_FMS;
      OPC_FNMA: if (funct7_i[1:0] == 2'b00) op_o = OP_FNMA;
      OPC_FNMS: if (funct7_i[1:0] == 2'b00) op_o = OP_FNMS;
      OPC_FPU: begin
        unique case (funct7_i)
          F7_ADD:  op_o = OP_FADD;
          F7_SUB:  op_o = OP_FSUB;
          F7_MUL:  op_o = OP_FMUL;
          F7_DIV:  op_o = OP_FDIV;
          F7_SQRT: if (rs2_zero) op_o = OP_FROOT;
          F7_SGN: begin
            unique case (funct3_i)
              3'b000:  op_o = OP_SIGN_COPY;
              3'b001:  op_o = OP_SIGN_NEG;
              3'b010:  op_o = OP_SIGN_XOR;
              default: op_o = OP_NOP;
            endcase
          end
          F7_MIN: if (funct3_i == 3'b000) op_o = OP_FMIN;
          F7_CMP: begin
            rd_int_o = 1'b1;
            unique case (funct3_i)
              3'b010:  op_o = OP_CMP_EQ;
              3'b001:  op_o = OP_CMP_LT;
              3'b000:  op_o = OP_CMP_LE;
              default: op_o = OP_NOP;
            endcase
          end
          F7_F2I: if (conv_ok) begin
            rd_int_o = 1'b1;
            unique case (conv_sel)
              2'd0:    op_o = OP_F2I_S32;
              2'd1:    op_o = OP_F2I_U32;
              2'd2:    op_o = OP_F2I_S64;
              default: op_o = OP_F2I_U64;
            endcase
          end
          F7_I2F: if (conv_ok) begin
            rs1_int_o = 1'b1;
            unique case (conv_sel)
              2'd0:    op_o = OP_I2F_S32;
              2'd1:    op_o = OP_I2F_U32;
              2'd2:    op_o = OP_I2F_S64;
              default: op_o = OP_I2F_U64;
            endcase
          end
          F7_MVX: if (rs2_zero) begin
            rd_int_o = 1'b1;
            if (funct3_i == 3'b000)      op_o = OP_BITS_F2I;
            else if (funct3_i == 3'b001) op_o = OP_CLASSIFY;
          end
          F7_MVF: if (rs2_zero && funct3_i == 3'b000) begin
            op_o = OP_BITS_I2F; rs1_int_o = 1'b1;
          end
          default: op_o = OP_NOP;
        endcase
      end
      default: op_o = OP_NOP;
    endcase
    illegal_o = (op_o == OP_NOP);
    if (illegal_o) begin
      rs1_int_o = 1'b0;
      rd_int_o  = 1'b0;
    end
  end

endmodule

// File: rtl/fp_insn_decoder.sv
module fp_insn_decoder
  import fpdec_pkg::*;
#(
  parameter int INT_XLEN = 32,
  parameter int IMM_W    = 32
) (
  input  logic [31:0]      insn_i,
  output logic [4:0]       op_o,
  output logic [4:0]       rd_o,
  output logic [4:0]       rs1_o,
  output logic [4:0]       rs2_o,
  output logic [4:0]       rs3_o,
  output logic [IMM_W-1:0] imm_o,
  output logic             rs1_int_o,
  output logic             rd_int_o,
  output logic             illegal_o
);
  logic [6:0]       opcode;
  logic [2:0]       funct3;
  logic [6:0]       funct7;
  logic [IMM_W-1:0] imm_ld;
  logic [IMM_W-1:0] imm_st;
  fp_op_e           op;
  imm_kind_e        imm_kind;

  fpdec_fields #(.IMM_W(IMM_W)) u_fields (
    .insn_i   (insn_i),
    .opcode_o (opcode),
    .funct3_o (funct3),
    .funct7_o (funct7),
    .rd_o     (rd_o),
    .rs1_o    (rs1_o),
    .rs2_o    (rs2_o),
    .rs3_o    (rs3_o),
    .imm_ld_o (imm_ld),
    .imm_st_o (imm_st)
  );

  fpdec_opmap #(.INT_XLEN(INT_XLEN)) u_opmap (
    .opcode_i   (opcode),
    .funct3_i   (funct3),
    .funct7_i   (funct7),
    .rs2_i      (rs2_o),
    .op_o       (op),
    .imm_kind_o (imm_kind),
    .rs1_int_o  (rs1_int_o),
    .rd_int_o   (rd_int_o),
    .illegal_o  (illegal_o)
  );

  always_comb begin
    op_o = op;
    unique case (imm_kind)
      IMM_LOAD:  imm_o = imm_ld;
      IMM_STORE: imm_o = imm_st;
      default:   imm_o = '0;
    endcase
  end

  // guards on the combined outputs
  always_comb begin
    if (!$isunknown(insn_i)) begin
      // R12: a rejected word leaves every other output quiet
      a_r12_illegal_quiet: assert (!illegal_o ||
        (op_o == 5'd0 && !rs1_int_o && !rd_int_o && imm_o == '0));
      // R13: only memory forms carry an offset
      a_r13_imm_mem_only: assert (op_o == OP_FLOAD || op_o == OP_FSTORE ||
        imm_o == '0);
      // R4: fused forms need the single-precision format bits
      a_r4_fused_fmt: assert (!(op_o inside {OP_FMA, OP_FMS, OP_FNMA, OP_FNMS}) ||
        insn_i[26:25] == 2'b00);
      // R10: narrow build never yields a 64-bit conversion
      a_r10_no_wide_conv: assert (INT_XLEN >= 64 ||
        !(op_o inside {OP_F2I_S64, OP_F2I_U64, OP_I2F_S64, OP_I2F_U64}));
      // R8: integer-writing forms raise the destination flag
      a_r8_int_dest: assert (!(op_o inside {OP_CMP_EQ, OP_CMP_LT, OP_CMP_LE,
        OP_CLASSIFY, OP_BITS_F2I}) || rd_int_o);
      // R2: memory forms take an integer base register
      a_r2_mem_base: assert (!(op_o inside {OP_FLOAD, OP_FSTORE}) ||
        (rs1_int_o && !rd_int_o));
    end
  end

endmodule

// File: tb/fp_insn_decoder_test.sv
`timescale 1ns/1ps
module fp_insn_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic clk;
  logic rst_n;
  logic [31:0] insn;
  logic [4:0]  op, rd, rs1, rs2, rs3;
  logic [31:0] imm;
  logic        rs1_int, rd_int, illegal;
  logic [4:0]  op64;
  logic [4:0]  rd64, rs1_64, rs2_64, rs3_64;
  logic [31:0] imm64;
  logic        rs1_int64, rd_int64, illegal64;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  fp_insn_decoder uut (
    .insn_i(insn), .op_o(op), .rd_o(rd), .rs1_o(rs1), .rs2_o(rs2),
    .rs3_o(rs3), .imm_o(imm), .rs1_int_o(rs1_int), .rd_int_o(rd_int),
    .illegal_o(illegal)
  );

  fp_insn_decoder #(.INT_XLEN(64)) uut64 (
    .insn_i(insn), .op_o(op64), .rd_o(rd64), .rs1_o(rs1_64), .rs2_o(rs2_64),
    .rs3_o(rs3_64), .imm_o(imm64), .rs1_int_o(rs1_int64), .rd_int_o(rd_int64),
    .illegal_o(illegal64)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] rtype(input logic [6:0] f7, input logic [4:0] s2,
                                        input logic [4:0] s1, input logic [2:0] f3,
                                        input logic [4:0] d, input logic [6:0] opc);
    return {f7, s2, s1, f3, d, opc};
  endfunction

  task automatic apply(input logic [31:0] w);
    @(posedge clk);
    #1 insn = w;
    #(CLK_PERIOD/2);
  endtask

  task automatic cmp(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // full check of the 32-bit instance
  task automatic expect_dec(input string req, input logic [4:0] e_op,
                            input logic e_r1, input logic e_rd,
                            input logic e_ill, input logic [31:0] e_imm);
    cmp(req, "op", {27'd0, op}, {27'd0, e_op});
    cmp(req, "flags", {29'd0, rs1_int, rd_int, illegal},
        {29'd0, e_r1, e_rd, e_ill});
    cmp(req, "imm", imm, e_imm);
  endtask

  task automatic t_reset;
    apply(32'h0);
    expect_dec("R12 reset/zero word", 5'd0, 1'b0, 1'b0, 1'b1, 32'h0);
  endtask

  task automatic t_load;
    apply({12'hFFC, 5'd3, 3'b010, 5'd7, 7'b0000111});
    expect_dec("R2 load neg", 5'd1, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFC);
    cmp("R13 rd", "rd", {27'd0, rd}, 32'd7);
    cmp("R13 rs1", "rs1", {27'd0, rs1}, 32'd3);
    apply({12'h7FF, 5'd1, 3'b010, 5'd2, 7'b0000111});
    expect_dec("R2 load max", 5'd1, 1'b1, 1'b0, 1'b0, 32'h0000_07FF);
    apply({12'h004, 5'd1, 3'b011, 5'd2, 7'b0000111});
    expect_dec("R2 load bad width", 5'd0, 1'b0, 1'b0, 1'b1, 32'h0);
  endtask

  task automatic t_store;
    apply({7'b1000000, 5'd9, 5'd2, 3'b010, 5'b00000, 7'b0100111});
    expect_dec("R3 store min", 5'd2, 1'b1, 1'b0, 1'b0, 32'hFFFF_F800);
    cmp("R13 rs2", "rs2", {27'd0, rs2}, 32'd9);
    apply({7'h3F, 5'd9, 5'd2, 3'b010, 5'h1F, 7'b0100111});
    expect_dec("R3 store max", 5'd2, 1'b1, 1'b0, 1'b0, 32'h0000_07FF);
    apply({7'h00, 5'd9, 5'd2, 3'b010, 5'h05, 7'b0100111});
    expect_dec("R3 store small", 5'd2, 1'b1, 1'b0, 1'b0, 32'h0000_0005);
  endtask

  task automatic t_fused;
    apply({5'd17, 2'b00, 5'd4, 5'd5, 3'b111, 5'd6, 7'b1000011});
    expect_dec("R4 madd", 5'd3, 1'b0, 1'b0, 1'b0, 32'h0);
    cmp("R4 rs3", "rs3", {27'd0, rs3}, 32'd17);
    apply({5'd1, 2'b00, 5'd4, 5'd5, 3'b000, 5'd6, 7'b1000111});
    expect_dec("R4 msub", 5'd4, 1'b0, 1'b0, 1'b0, 32'h0);
    apply({5'd1, 2'b00, 5'd4, 5'd5, 3'b000, 5'd6, 7'b1001111});
    expect_dec("R4 nmadd", 5'd5, 1'b0, 1'b0, 1'b0, 32'h0);
    apply({5'd1, 2'b00, 5'd4, 5'd5, 3'b000, 5'd6, 7'b1001011});
    expect_dec("R4 nmsub", 5'd6, 1'b0, 1'b0, 1'b0, 32'h0);
    apply({5'd1, 2'b01, 5'd4, 5'd5, 3'b000, 5'd6, 7'b1000011});
    expect_dec("R4 fmt 01", 5'd0, 1'b0, 1'b0, 1'b1, 32'h0);
    apply({5'd1, 2'b10, 5'd4, 5'd5, 3'b000, 5'd6, 7'b1001011});
    expect_dec("R4 fmt 10", 5'd0, 1'b0, 1'b0, 1'b1, 32'h0);
  endtask

  task automatic t_arith;
    apply(rtype(7'b0000000, 5'd2, 5'd1, 3'b111, 5'd3, 7'b1010011));
    expect_dec("R5 add rm7", 5'd7, 1'b0, 1'b0, 1'b0, 32'h0);
    apply(rtype(7'b0000100, 5'd2, 5'd1, 3'b000, 5'd3, 7'b1010011));
    expect_dec("R5 sub", 5'd8, 1'b0, 1'b0, 1'b0, 32'h0);
    apply(rtype(7'b0001000, 5'd2, 5'd1, 3'b011, 5'd3, 7'b1010011));
    expect_dec("R5 mul", 5'd9, 1'b0, 1'b0, 1'b0, 32'h0);
    apply(rtype(7'b0001100, 5'd2, 5'd1, 3'b001, 5'd3, 7'b1010011));
    expect_dec("R5 div", 5'd10, 1'b0, 1'b0, 1'b0, 32'h0);
    apply(rtype(7'b0101100, 5'd0, 5'd1, 3'b000, 5'd3, 7'b1010011));
    expect_dec("R5 sqrt", 5'd11, 1'b0, 1'b0, 1'b0, 32'h0);
    apply(rtype(7'b0101100, 5'd16, 5'd1, 3'b000, 5'd3, 7'b1010011));
    expect_dec("R5 sqrt rs2!=0", 5'd0, 1'b0, 1'b0, 1'b1, 32'h0);
  endtask

  task automatic t_sign_min;
    apply(rtype(7'b0010000, 5'd2, 5'd1, 3'b000, 5'd3, 7'b1010011));
    expect_dec("R6 copy", 5'd12, 1'b0, 1'b0, 1'b0, 32'h0);
    apply(rtype(7'b0010000, 5'd2, 5'd1, 3'b001, 5'd3, 7'b1010011));
    expect_dec("R6 neg", 5'd13, 1'b0, 1'b0, 1'b0, 32'h0);
    apply(rtype(7'b0010000, 5'd2, 5'd1, 3'b010, 5'd3, 7'b1010011));
    expect_dec("R6 xor", 5'd14, 1'b0, 1'b0, 1'b0, 32'h0);
    apply(rtype(7'b0010000, 5'd2, 5'd1, 3'b011, 5'd3, 7'b1010011));
    expect_dec("R6 bad f3", 5'd0, 1'b0, 1'b0, 1'b1, 32'h0);
    apply(rtype(7'b0010100, 5'd2, 5'd1, 3'b000, 5'd3, 7'b1010011));
    expect_dec("R7 min", 5'd15, 1'b0, 1'b0, 1'b0, 32'h0);
    apply(rtype(7'b0010100, 5'd2, 5'd1, 3'b001, 5'd3, 7'b1010011));
    expect_dec("R7 min f3=1", 5'd0, 1'b0, 1'b0, 1'b1, 32'h0);
  endtask

  task automatic t_compare;
    apply(rtype(7'b1010000, 5'd2, 5'd1, 3'b010, 5'd3, 7'b1010011));
    expect_dec("R8 eq", 5'd16, 1'b0, 1'b1, 1'b0, 32'h0);
    apply(rtype(7'b1010000, 5'd2, 5'd1, 3'b001, 5'd3, 7'b1010011));
    expect_dec("R8 lt", 5'd17, 1'b0, 1'b1, 1'b0, 32'h0);
    apply(rtype(7'b1010000, 5'd2, 5'd1, 3'b000, 5'd3, 7'b1010011));
    expect_dec("R8 le", 5'd18, 1'b0, 1'b1, 1'b0, 32'h0);
    apply(rtype(7'b1010000, 5'd2, 5'd1, 3'b011, 5'd3, 7'b1010011));
    expect_dec("R8 bad f3", 5'd0, 1'b0, 1'b0, 1'b1, 32'h0);
  endtask

  task automatic t_convert;
    apply(rtype(7'b1100000, 5'd0, 5'd1, 3'b000, 5'd3, 7'b1010011));
    expect_dec("R9 f2i s32", 5'd19, 1'b0, 1'b1, 1'b0, 32'h0);
    apply(rtype(7'b1100000, 5'd1, 5'd1, 3'b001, 5'd3, 7'b1010011));
    expect_dec("R9 f2i u32", 5'd20, 1'b0, 1'b1, 1'b0, 32'h0);
    apply(rtype(7'b1101000, 5'd0, 5'd1, 3'b000, 5'd3, 7'b1010011));
    expect_dec("R9 i2f s32", 5'd23, 1'b1, 1'b0, 1'b0, 32'h0);
    apply(rtype(7'b1101000, 5'd1, 5'd1, 3'b000, 5'd3, 7'b1010011));
    expect_dec("R9 i2f u32", 5'd24, 1'b1, 1'b0, 1'b0, 32'h0);
    apply(rtype(7'b1100000, 5'd4, 5'd1, 3'b000, 5'd3, 7'b1010011));
    expect_dec("R9 f2i type4", 5'd0, 1'b0, 1'b0, 1'b1, 32'h0);
    cmp("R9 type4 wide", "op64", {27'd0, op64}, 32'd0);
    // R10: 64-bit types depend on INT_XLEN
    apply(rtype(7'b1100000, 5'd2, 5'd1, 3'b000, 5'd3, 7'b1010011));
    expect_dec("R10 f2i s64 narrow", 5'd0, 1'b0, 1'b0, 1'b1, 32'h0);
    cmp("R10 f2i s64 wide", "op64", {27'd0, op64}, 32'd21);
    cmp("R10 f2i s64 wide", "rd_int64", {31'd0, rd_int64}, 32'd1);
    apply(rtype(7'b1100000, 5'd3, 5'd1, 3'b000, 5'd3, 7'b1010011));
    cmp("R10 f2i u64 wide", "op64", {27'd0, op64}, 32'd22);
    cmp("R10 f2i u64 narrow", "illegal", {31'd0, illegal}, 32'd1);
    apply(rtype(7'b1101000, 5'd2, 5'd1, 3'b000, 5'd3, 7'b1010011));
    cmp("R10 i2f s64 wide", "op64", {27'd0, op64}, 32'd25);
    cmp("R10 i2f s64 wide", "rs1_int64", {31'd0, rs1_int64}, 32'd1);
    apply(rtype(7'b1101000, 5'd3, 5'd1, 3'b000, 5'd3, 7'b1010011));
    cmp("R10 i2f u64 wide", "op64", {27'd0, op64}, 32'd26);
    expect_dec("R10 i2f u64 narrow", 5'd0, 1'b0, 1'b0, 1'b1, 32'h0);
  endtask

  task automatic t_move;
    apply(rtype(7'b1110000, 5'd0, 5'd1, 3'b000, 5'd3, 7'b1010011));
    expect_dec("R11 bits to int", 5'd27, 1'b0, 1'b1, 1'b0, 32'h0);
    apply(rtype(7'b1110000, 5'd0, 5'd1, 3'b001, 5'd3, 7'b1010011));
    expect_dec("R11 classify", 5'd28, 1'b0, 1'b1, 1'b0, 32'h0);
    apply(rtype(7'b1110000, 5'd0, 5'd1, 3'b010, 5'd3, 7'b1010011));
    expect_dec("R11 f3=2", 5'd0, 1'b0, 1'b0, 1'b1, 32'h0);
    apply(rtype(7'b1110000, 5'd1, 5'd1, 3'b000, 5'd3, 7'b1010011));
    expect_dec("R11 rs2!=0", 5'd0, 1'b0, 1'b0, 1'b1, 32'h0);
    apply(rtype(7'b1111000, 5'd0, 5'd1, 3'b000, 5'd3, 7'b1010011));
    expect_dec("R11 bits to fp", 5'd29, 1'b1, 1'b0, 1'b0, 32'h0);
    apply(rtype(7'b1111000, 5'd0, 5'd1, 3'b001, 5'd3, 7'b1010011));
    expect_dec("R11 to fp f3=1", 5'd0, 1'b0, 1'b0, 1'b1, 32'h0);
  endtask

  task automatic t_illegal;
    apply(rtype(7'b0000000, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011));
    expect_dec("R12 foreign opcode", 5'd0, 1'b0, 1'b0, 1'b1, 32'h0);
    apply(rtype(7'b0000001, 5'd2, 5'd1, 3'b000, 5'd3, 7'b1010011));
    expect_dec("R12 unknown funct7", 5'd0, 1'b0, 1'b0, 1'b1, 32'h0);
    apply(rtype(7'b0010101, 5'd2, 5'd1, 3'b000, 5'd3, 7'b1010011));
    expect_dec("R12 double fmt", 5'd0, 1'b0, 1'b0, 1'b1, 32'h0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    insn  = 32'h0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_store();
    t_fused();
    t_arith();
    t_sign_min();
    t_compare();
    t_convert();
    t_move();
    t_illegal();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule